// File: doc/BRIEF.md
# Per-PC Stride Prefetcher

The block watches the stream of executed loads. Each load brings a program counter and an effective address. The low part of the program counter selects one entry of a small direct-mapped table. The remaining upper bits are kept in that entry as a tag. An entry holds the last address seen for that load, a signed stride, and a two-bit confidence state.

Each access to an entry compares the new address with the address the entry predicted. A four-state confidence machine uses the result to decide whether the stride is trusted, and whether to replace it with the newly observed difference. When an access leaves its entry in the trusted state, the block offers one prefetch address on the next cycle. That address is the current load address plus the stride.

The prefetch port uses a valid/ready handshake. The load stream never waits on it. An offer that is not accepted in its single cycle is discarded.

Top module: `stride_pf`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pf_valid` is low. Reset empties every table entry, so the first load of any PC is a miss.
- R2: Index and tag come from the PC. The entry index is `ld_pc[PC_LSB +: IDX_W]`, and the tag is the bits above it. A load whose tag does not match the valid entry at its index is a miss. A miss overwrites that entry: the new tag, previous address = load address, stride 0, state init. A miss never produces a prefetch.
- R3: A hit is predicted correctly when the load address equals the stored previous address plus the stored stride, modulo 2^ADDR_W.
- R4: From init, a correct access moves to steady. An incorrect access moves to transient and sets the stride to the load address minus the previous address.
- R5: From transient, a correct access moves to steady. An incorrect access moves to no-prediction and sets the stride to the new difference.
- R6: From steady, a correct access stays in steady. An incorrect access returns to init and keeps the stored stride unchanged.
- R7: From no-prediction, a correct access moves to transient and gives no prefetch. An incorrect access stays in no-prediction and takes the new difference as its stride.
- R8: Every access to an entry, hit or miss, sets that entry's previous address to the load address.
- R9: A hit whose new state is steady raises `pf_valid` on the next cycle, with `pf_addr` = load address + stride. No other access produces a prefetch.
- R10: `pf_valid` is high for exactly the one cycle after the triggering load, whatever the value of `pf_ready`. An offer that is not accepted is dropped, and the block never stalls loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load is observed this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Effective address of the load |
| pf_valid | output | 1 | Prefetch address offered this cycle |
| pf_addr | output | ADDR_W | Prefetch address |
| pf_ready | input | 1 | Consumer accepts the offered prefetch |

## Verification
The embedded properties check the local rules on every cycle:
- A no-prediction entry never jumps straight to steady.
- A steady entry only stays steady or falls back to init.
- A steady entry's stride changes only on a replacement.
- Misses yield no prefetch.
- An offer never outlives its cycle when it is refused.

Whether the prefetch address is numerically right, and whether each correct or incorrect outcome follows the four-state table, depends on the history of each PC. Only the bench's directed sequences and its randomized PC/stride mixture against a reference table can show that, together with the aliasing between PCs that share an index.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

   typedef enum logic [1:0] {
      CONF_INIT   = 2'd0,
      CONF_TRANS  = 2'd1,
      CONF_STEADY = 2'd2,
      CONF_NOPRED = 2'd3
   } conf_e;

endpackage

// File: rtl/stride_pf_fsm.sv
module stride_pf_fsm
   import stride_pf_pkg::*;
(
   input  conf_e cur_state,
   input  logic  correct,
   output conf_e nxt_state,
   output logic  take_stride
);

   always_comb begin
      nxt_state   = cur_state;
      take_stride = 1'b0;
      unique case (cur_state)
         CONF_INIT: begin
            if (correct) begin
               nxt_state = CONF_STEADY;
            end else begin
               nxt_state   = CONF_TRANS;
               take_stride = 1'b1;
            end
         end
         CONF_TRANS: begin
            if (correct) begin
               nxt_state = CONF_STEADY;
            end else begin
               nxt_state   = CONF_NOPRED;
               take_stride = 1'b1;
            end
         end
         CONF_STEADY: begin
            nxt_state = correct ? CONF_STEADY : CONF_INIT;
         end
         CONF_NOPRED: begin
            if (correct) begin
               nxt_state = CONF_TRANS;
            end else begin
               take_stride = 1'b1;
            end
         end
         default: begin
            nxt_state = CONF_INIT;
         end
      endcase
   end

endmodule

// File: rtl/stride_pf_table.sv
module stride_pf_table
   import stride_pf_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 26,
   parameter int ADDR_W  = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [ADDR_W-1:0] rd_prev,
   output logic [ADDR_W-1:0] rd_stride,
   output conf_e             rd_state,
   input  logic              wr_en,
   input  logic              wr_alloc,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [ADDR_W-1:0] wr_prev,
   input  logic [ADDR_W-1:0] wr_stride,
   input  conf_e             wr_state
);

   logic              valid_a  [ENTRIES];
   logic [TAG_W-1:0]  tag_a    [ENTRIES];
   logic [ADDR_W-1:0] prev_a   [ENTRIES];
   logic [ADDR_W-1:0] stride_a [ENTRIES];
   conf_e             state_a  [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic              v_q;
      logic [TAG_W-1:0]  tag_q;
      logic [ADDR_W-1:0] prev_q;
      logic [ADDR_W-1:0] stride_q;
      conf_e             st_q;
      logic              sel;

      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q      <= 1'b0;
            tag_q    <= '0;
            prev_q   <= '0;
            stride_q <= '0;
            st_q     <= CONF_INIT;
         end else if (sel) begin
            v_q      <= 1'b1;
            tag_q    <= wr_tag;
            prev_q   <= wr_prev;
            stride_q <= wr_stride;
            st_q     <= wr_state;
         end
      end

      assign valid_a[e]  = v_q;
      assign tag_a[e]    = tag_q;
      assign prev_a[e]   = prev_q;
      assign stride_a[e] = stride_q;
      assign state_a[e]  = st_q;

      // R7: leaving no-prediction never lands directly in steady
      a_r7_nopred_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q == CONF_NOPRED) |=> (st_q != CONF_STEADY));

      // R6: a steady entry either stays steady or drops to init
      a_r6_steady_exits: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q == CONF_STEADY) |=> (st_q == CONF_STEADY || st_q == CONF_INIT));

      // R6: the stride of a steady entry survives everything except replacement
      a_r6_stride_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q == CONF_STEADY && !(sel && wr_alloc)) |=> $stable(stride_q));
   end

   assign rd_valid  = valid_a[rd_idx];
   assign rd_tag    = tag_a[rd_idx];
   assign rd_prev   = prev_a[rd_idx];
   assign rd_stride = stride_a[rd_idx];
   assign rd_state  = state_a[rd_idx];

endmodule

// File: rtl/stride_pf_issue.sv
module stride_pf_issue #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr,
   input  logic              pf_ready
);

   logic              vld_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         vld_q <= req;
         if (req) begin
            addr_q <= req_addr;
         end
      end
   end

   assign pf_valid = vld_q;
   assign pf_addr  = addr_q;

   // R10: a refused offer is gone next cycle unless a fresh request arrived
   a_r10_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready && !req) |=> !pf_valid);

endmodule

// File: rtl/stride_pf.sv
module stride_pf
   import stride_pf_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 16,
   parameter int PC_LSB  = 2,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int TAG_W  = PC_W - PC_LSB - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [PC_W-1:0]   ld_pc,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr,
   input  logic              pf_ready
);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("stride_pf: ENTRIES must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("stride_pf: PC_W too small for PC_LSB and ENTRIES");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("stride_pf: ADDR_W must be at least 2");
   end

   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  tag;
   logic              e_valid;
   logic [TAG_W-1:0]  e_tag;
   logic [ADDR_W-1:0] e_prev;
   logic [ADDR_W-1:0] e_stride;
   conf_e             e_state;
   logic              hit;
   logic              correct;
   logic [ADDR_W-1:0] diff;
   conf_e             fsm_next;
   logic              fsm_take;
   logic [ADDR_W-1:0] new_stride;
   conf_e             new_state;
   logic              req;
   logic [ADDR_W-1:0] req_addr;

   assign idx = ld_pc[PC_LSB +: IDX_W];
   assign tag = ld_pc[PC_W-1 -: TAG_W];

   stride_pf_table #(
      .ENTRIES (ENTRIES),
      .TAG_W   (TAG_W),
      .ADDR_W  (ADDR_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (idx),
      .rd_valid  (e_valid),
      .rd_tag    (e_tag),
      .rd_prev   (e_prev),
      .rd_stride (e_stride),
      .rd_state  (e_state),
      .wr_en     (ld_valid),
      .wr_alloc  (!hit),
      .wr_idx    (idx),
      .wr_tag    (tag),
      .wr_prev   (ld_addr),
      .wr_stride (new_stride),
      .wr_state  (new_state)
   );

   assign hit     = e_valid && (e_tag == tag);
   assign correct = (ld_addr == e_prev + e_stride);
   assign diff    = ld_addr - e_prev;

   stride_pf_fsm u_fsm (
      .cur_state   (e_state),
      .correct     (correct),
      .nxt_state   (fsm_next),
      .take_stride (fsm_take)
   );

   always_comb begin
      if (hit) begin
         new_state  = fsm_next;
         new_stride = fsm_take ? diff : e_stride;
      end else begin
         new_state  = CONF_INIT;
         new_stride = '0;
      end
   end

   assign req      = ld_valid && hit && (fsm_next == CONF_STEADY);
   assign req_addr = ld_addr + new_stride;

   stride_pf_issue #(
      .ADDR_W (ADDR_W)
   ) u_issue (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .req_addr (req_addr),
      .pf_valid (pf_valid),
      .pf_addr  (pf_addr),
      .pf_ready (pf_ready)
   );

   // R9: an offer only ever follows an observed load
   a_r9_pf_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> $past(ld_valid));

   // R2: a table miss never yields a prefetch
   a_r2_miss_no_pf: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !hit) |=> !pf_valid);

endmodule

// File: tb/sim_stride_pf.sv
module sim_stride_pf;

   localparam int PC_W    = 32;
   localparam int ADDR_W  = 32;
   localparam int ENTRIES = 16;
   localparam int PC_LSB  = 2;
   localparam int IDX_W   = $clog2(ENTRIES);
   localparam int TAG_W   = PC_W - PC_LSB - IDX_W;
   localparam int S_INIT = 0, S_TRANS = 1, S_STEADY = 2, S_NOPRED = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ld_valid = 1'b0;
   logic [PC_W-1:0]   ld_pc = '0;
   logic [ADDR_W-1:0] ld_addr = '0;
   logic              pf_valid;
   logic [ADDR_W-1:0] pf_addr;
   logic              pf_ready = 1'b1;

   always #5 clk = ~clk;

   stride_pf #(
      .PC_W (PC_W), .ADDR_W (ADDR_W), .ENTRIES (ENTRIES), .PC_LSB (PC_LSB)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .ld_valid (ld_valid), .ld_pc (ld_pc),
      .ld_addr (ld_addr), .pf_valid (pf_valid), .pf_addr (pf_addr),
      .pf_ready (pf_ready)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   bit              m_v      [ENTRIES];
   bit [TAG_W-1:0]  m_tag    [ENTRIES];
   bit [ADDR_W-1:0] m_prev   [ENTRIES];
   bit [ADDR_W-1:0] m_stride [ENTRIES];
   int              m_st     [ENTRIES];

   bit              exp_v = 0;
   bit [ADDR_W-1:0] exp_a = '0;
   string           exp_tag = "R9";

   function automatic bit [PC_W-1:0] mk_pc(int unsigned i, int unsigned t);
      return PC_W'((t << (PC_LSB + IDX_W)) | (i << PC_LSB));
   endfunction

   task automatic check_out(string req);
      total++;
      if (pf_valid !== exp_v || (exp_v && pf_addr !== exp_a)) begin
         bad++;
         $display("FAIL %s: pf_valid=%0b pf_addr=%h expected valid=%0b addr=%h",
                  req, pf_valid, pf_addr, exp_v, exp_a);
      end
   endtask

   // reference model of one access, giving the expected offer for next cycle
   task automatic model(bit [PC_W-1:0] pc, bit [ADDR_W-1:0] a);
      int i = int'(pc[PC_LSB +: IDX_W]);
      bit [TAG_W-1:0] t = pc[PC_W-1 -: TAG_W];
      bit ok;
      bit [ADDR_W-1:0] d;
      exp_v = 0;
      if (!m_v[i] || m_tag[i] != t) begin
         m_v[i] = 1; m_tag[i] = t; m_prev[i] = a; m_stride[i] = '0; m_st[i] = S_INIT;
         return;
      end
      ok = (a == m_prev[i] + m_stride[i]);
      d  = a - m_prev[i];
      case (m_st[i])
         S_INIT:   if (ok) m_st[i] = S_STEADY; else begin m_st[i] = S_TRANS;  m_stride[i] = d; end
         S_TRANS:  if (ok) m_st[i] = S_STEADY; else begin m_st[i] = S_NOPRED; m_stride[i] = d; end
         S_STEADY: if (!ok) m_st[i] = S_INIT;
         default:  if (ok) m_st[i] = S_TRANS;  else m_stride[i] = d;
      endcase
      m_prev[i] = a;
      if (m_st[i] == S_STEADY) begin
         exp_v = 1;
         exp_a = a + m_stride[i];
      end
   endtask

   // check the previous cycle's result, then present the next load
   task automatic step(bit v, bit [PC_W-1:0] pc, bit [ADDR_W-1:0] a, bit rdy, string req);
      @(negedge clk);
      check_out(exp_tag);
      pf_ready = rdy;
      ld_valid = v;
      ld_pc    = pc;
      ld_addr  = a;
      exp_tag  = req;
      if (v) model(pc, a);
      else exp_v = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit [PC_W-1:0]   pa, pb, pc2;
      bit [ADDR_W-1:0] base;
      bit [ADDR_W-1:0] r_addr [8];
      bit [ADDR_W-1:0] r_str  [8];
      for (int k = 0; k < ENTRIES; k++) begin
         m_v[k] = 0; m_tag[k] = '0; m_prev[k] = '0; m_stride[k] = '0; m_st[k] = S_INIT;
      end
      void'($urandom(32'd7341));
      repeat (3) @(negedge clk);
      total++;
      if (pf_valid !== 1'b0) begin
         bad++;
         $display("FAIL R1: pf_valid=%0b in reset, expected 0", pf_valid);
      end
      rst_n = 1'b1;
      exp_tag = "R1";

      pa = mk_pc(3, 5);
      pb = mk_pc(6, 9);
      pc2 = mk_pc(3, 12);   // aliases pa's index with another tag
      base = 32'h0000_1000;

      // R2 first touch: miss, no prefetch
      step(1, pa, base, 1, "R2");
      // R4 init incorrect -> transient, stride 8
      step(1, pa, base + 8, 1, "R4");
      // R5 transient correct -> steady, prefetch base+24 (R9)
      step(1, pa, base + 16, 1, "R5");
      // R6 steady correct, prefetch refused: R10 offer not held
      step(1, pa, base + 24, 0, "R6");
      step(0, pa, '0, 0, "R10");
      step(0, pa, '0, 1, "R10");
      // R6 steady incorrect -> init, stride kept
      step(1, pa, base + 100, 1, "R6");
      // R4 init correct with kept stride 8 -> steady, R8 prev updated
      step(1, pa, base + 108, 1, "R4");
      step(1, pa, base + 116, 1, "R8");

      // R7 path on another PC
      step(1, pb, 32'h0000_8000, 1, "R2");
      step(1, pb, 32'h0000_8005, 1, "R4");
      step(1, pb, 32'h0000_8064, 1, "R5");   // transient incorrect -> no-prediction
      step(1, pb, 32'h0000_8100, 1, "R7");   // incorrect again, stays, new stride
      step(1, pb, 32'h0000_819C, 1, "R7");   // correct -> transient, no prefetch
      step(1, pb, 32'h0000_8238, 1, "R5");   // correct -> steady, prefetch
      // R3 wrap-around arithmetic
      step(1, pb, 32'hFFFF_FFF0, 1, "R3");
      step(1, pb, 32'h0000_0008, 1, "R3");
      step(1, pb, 32'h0000_0020, 1, "R3");

      // R2 aliasing: other tag replaces pa's entry, then pa misses again
      step(1, pc2, 32'h0004_0000, 1, "R2");
      step(1, pa,  base + 124, 1, "R2");
      step(1, pa,  base + 132, 1, "R2");
      step(1, pa,  base + 140, 1, "R9");
      step(0, pa, '0, 1, "R9");

      // randomized mixture of strided streams with aliasing PCs
      for (int k = 0; k < 8; k++) begin
         r_addr[k] = $urandom;
         r_str[k]  = ($urandom_range(0, 15) - 8) * 4;
      end
      for (int n = 0; n < 4000; n++) begin
         int k = $urandom_range(0, 7);
         int sel = $urandom_range(0, 99);
         if (sel < 8) r_addr[k] = $urandom;
         else if (sel < 12) r_str[k] = ($urandom_range(0, 31) - 16) * 8;
         else r_addr[k] = r_addr[k] + r_str[k];
         step($urandom_range(0, 9) != 0, mk_pc(k % 4, k / 4 + 1), r_addr[k],
              $urandom_range(0, 1), "R9");
      end
      step(0, pa, '0, 1, "R10");
      step(0, pa, '0, 1, "R10");

      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule